// File: doc/BRIEF.md
# Slow Sampling-Clock Detector with Backup Oscillator Enable

This block watches a sampling clock and decides whether it has become too slow for circuits that depend on it. When the rate is too low, it raises an enable for a backup oscillator so that those circuits keep working. It measures the rate against a free-running reference clock. It counts the sampling clock's rising edges during a fixed window of reference cycles, then compares the count with two thresholds that form a hysteresis band.

A two-bit control register holds the block's settings. One bit turns detection on; with it off, the block never reports a slow clock. The other bit forces the oscillator enable on, whatever the detector decides. Both outputs are registered and change only at window boundaries. A sampling clock that stops entirely produces a zero count and reads as slow. With the defaults (1024 reference cycles, thresholds of 51 and 56 edges, and a 100 MHz reference), the trip point falls near 5 MHz.

Top module: `lowrate_osc_ctl`

## Requirements
- R1: With detection enabled and the status currently clear, a window of WINDOW_CYCLES reference cycles that counts fewer than LOW_EDGES (default 51) monitored rising edges sets `low_rate` to 1 at the end of that window.
- R2: Once `low_rate` is 1, it clears only at the end of a window that counts at least HIGH_EDGES (default 56) edges. A window whose count lies between the two thresholds leaves `low_rate` unchanged, whether it was 1 or 0.
- R3: A monitored clock that stops entirely makes `low_rate` 1 (with detection enabled).
- R4: At each window end, `osc_en` takes the value force-run OR (detect-enable AND the new `low_rate`).
- R5: With detect-enable at 0, the next window end clears `low_rate`, and `osc_en` follows the force-run bit alone.
- R6: With force-run at 1, `osc_en` is 1 after the next window end, for any monitored rate.
- R7: A one-cycle pulse on `ctl_we` loads `ctl_wdata`, where bit 0 is detect-enable and bit 1 is force-run. Reset sets detect-enable to 1 and force-run to 0, and drives `low_rate` and `osc_en` to 0.
- R8: `low_rate` and `osc_en` change only on the reference edge that ends a window. A control write made during a window does not affect the outputs until the end of that window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock; all control and outputs are in this domain |
| rst | input | 1 | Synchronous active-high reset (reference domain) |
| clk_mon | input | 1 | Sampling clock whose rate is watched |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control value: bit 0 detect-enable, bit 1 force-run |
| osc_en | output | 1 | Enable for the backup oscillator |
| low_rate | output | 1 | Monitored clock judged too slow |

## Verification
An error in the window timer or the edge counter shows up at the ports as a wrong decision. Such an error is only visible for rates near a threshold, and only at the window boundary that follows. A flipped hysteresis state therefore appears within one window, but only while the monitored rate is inside the band. For that reason the band is tested after entering it from both sides. A wrong control-register reset value or bit order shows up at the first window end after reset or after a write. A decision register that updates away from the window end shows up as an output change in the middle of a window, which the bench watches on every cycle.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
  // Bit positions of the control word; the testbench and software rely on them.
  localparam int CTL_DET_BIT   = 0;
  localparam int CTL_FORCE_BIT = 1;

  typedef struct packed {
    logic force_run;  // bit 1
    logic detect_on;  // bit 0
  } lrd_ctl_t;

  localparam lrd_ctl_t CTL_RESET = '{force_run: 1'b0, detect_on: 1'b1};
endpackage

// File: rtl/lrd_edge_sync.sv
// Carries each monitored rising edge into the reference domain as a
// single-cycle pulse, using a toggle flop and a synchronizer chain.
module lrd_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_mon,
  input  logic clk_ref,
  input  logic rst,
  output logic edge_pulse
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic             tog_mon;
  logic [CHAIN-1:0] sync_q;

  // The reset is asserted asynchronously in the monitored domain, because that
  // clock may be stopped. A skewed release costs at most one counted edge.
  always_ff @(posedge clk_mon or posedge rst) begin
    if (rst) tog_mon <= 1'b0;
    else     tog_mon <= ~tog_mon;
  end

  always_ff @(posedge clk_ref) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[CHAIN-2:0], tog_mon};
  end

  assign edge_pulse = sync_q[CHAIN-1] ^ sync_q[CHAIN-2];
endmodule

// File: rtl/lrd_window_counter.sv
// Fixed-length measurement window and the edge count within it.
module lrd_window_counter #(
  parameter int WINDOW_CYCLES = 1024,
  parameter int CNT_W         = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_pulse,
  output logic             win_end,
  output logic [CNT_W-1:0] edge_total
);
  localparam int WIN_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WINDOW_CYCLES - 1);

  logic [WIN_W-1:0] wcnt_q;
  logic [CNT_W-1:0] ecnt_q;

  assign win_end    = (wcnt_q == LAST);
  // The edge that arrives in the final cycle still belongs to this window.
  assign edge_total = ecnt_q + CNT_W'(edge_pulse);

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
    end else if (win_end) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
    end else begin
      wcnt_q <= wcnt_q + 1'b1;
      ecnt_q <= edge_total;
    end
  end

  // At most one edge per reference cycle, so the count never exceeds elapsed cycles.
  assert_edges_bounded_R1: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(wcnt_q) >= ecnt_q);
endmodule

// File: rtl/lrd_rate_judge.sv
// Hysteresis decision and registered outputs, updated once per window.
module lrd_rate_judge #(
  parameter int CNT_W      = 11,
  parameter int LOW_EDGES  = 51,
  parameter int HIGH_EDGES = 56
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_end,
  input  logic [CNT_W-1:0] edge_total,
  input  logic             det_en,
  input  logic             force_on,
  output logic             low_rate,
  output logic             osc_en
);
  localparam logic [CNT_W-1:0] ENTER_K = CNT_W'(LOW_EDGES);
  localparam logic [CNT_W-1:0] LEAVE_K = CNT_W'(HIGH_EDGES);

  logic next_low;

  always_comb begin
    if (!det_en)       next_low = 1'b0;
    else if (low_rate) next_low = (edge_total < LEAVE_K);
    else               next_low = (edge_total < ENTER_K);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_rate <= 1'b0;
      osc_en   <= 1'b0;
    end else if (win_end) begin
      low_rate <= next_low;
      osc_en   <= force_on | next_low;
    end
  end

  assert_hold_midwindow_R8: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> ($stable(low_rate) && $stable(osc_en)));

  assert_force_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (win_end && force_on) |=> osc_en);

  assert_det_off_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (win_end && !det_en) |=> !low_rate);

  assert_slow_enters_R1: assert property (@(posedge clk) disable iff (rst)
    (win_end && det_en && !low_rate && (edge_total < ENTER_K)) |=> low_rate);

  assert_band_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (win_end && det_en && low_rate && (edge_total < LEAVE_K)) |=> low_rate);
endmodule

// File: rtl/lowrate_osc_ctl.sv
module lowrate_osc_ctl #(
  parameter int WINDOW_CYCLES = 1024,
  parameter int LOW_EDGES     = 51,
  parameter int HIGH_EDGES    = 56,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_ref,
  input  logic       rst,
  input  logic       clk_mon,
  input  logic       ctl_we,
  input  logic [1:0] ctl_wdata,
  output logic       osc_en,
  output logic       low_rate
);
  import lrd_pkg::*;

  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);

  lrd_ctl_t         ctl_q;
  logic             edge_pulse;
  logic             win_end;
  logic [CNT_W-1:0] edge_total;

  always_ff @(posedge clk_ref) begin
    if (rst)         ctl_q <= CTL_RESET;
    else if (ctl_we) ctl_q <= lrd_ctl_t'(ctl_wdata);
  end

  lrd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_mon    (clk_mon),
    .clk_ref    (clk_ref),
    .rst        (rst),
    .edge_pulse (edge_pulse)
  );

  lrd_window_counter #(.WINDOW_CYCLES(WINDOW_CYCLES), .CNT_W(CNT_W)) u_win (
    .clk        (clk_ref),
    .rst        (rst),
    .edge_pulse (edge_pulse),
    .win_end    (win_end),
    .edge_total (edge_total)
  );

  lrd_rate_judge #(.CNT_W(CNT_W), .LOW_EDGES(LOW_EDGES), .HIGH_EDGES(HIGH_EDGES)) u_judge (
    .clk        (clk_ref),
    .rst        (rst),
    .win_end    (win_end),
    .edge_total (edge_total),
    .det_en     (ctl_q.detect_on),
    .force_on   (ctl_q.force_run),
    .low_rate   (low_rate),
    .osc_en     (osc_en)
  );

  assert_ctl_load_R7: assert property (@(posedge clk_ref) disable iff (rst)
    ctl_we |=> (ctl_q.detect_on == $past(ctl_wdata[CTL_DET_BIT]) &&
                ctl_q.force_run == $past(ctl_wdata[CTL_FORCE_BIT])));
endmodule

// File: tb/lowrate_osc_ctl_tb.sv
`timescale 1ns/1ps
module lowrate_osc_ctl_tb;
  localparam int W    = 1024;
  localparam int LOWK = 51;
  localparam int HIGK = 56;
  localparam int MID  = 512;

  logic       clk_ref = 1'b0;
  logic       rst = 1'b1;
  logic       clk_mon = 1'b0;
  logic       ctl_we = 1'b0;
  logic [1:0] ctl_wdata = 2'b00;
  logic       osc_en, low_rate;

  int  mon_per = 200;   // ns; 0 means stopped
  int  cyc = 0;         // reference edges since reset release
  int  checks = 0, fails = 0, midwin_bad = 0;
  bit  done = 0;
  logic prev_low = 1'b0, prev_osc = 1'b0;

  always #2 clk_ref = ~clk_ref;   // 250 MHz reference

  always begin
    if (mon_per == 0) begin
      clk_mon = 1'b0;
      #7;
    end else begin
      #(mon_per * 0.5);
      clk_mon = ~clk_mon;
    end
  end

  lowrate_osc_ctl #(.WINDOW_CYCLES(W), .LOW_EDGES(LOWK), .HIGH_EDGES(HIGK)) u_dut (
    .clk_ref(clk_ref), .rst(rst), .clk_mon(clk_mon), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .osc_en(osc_en), .low_rate(low_rate));

  always @(posedge clk_ref) if (!rst) cyc <= cyc + 1;

  // R8 monitor: outputs may move only after an edge that closes a window.
  always @(negedge clk_ref) begin
    if (!rst && cyc > 0) begin
      if ((low_rate !== prev_low || osc_en !== prev_osc) && (cyc % W) != 0)
        midwin_bad++;
    end
    prev_low = low_rate;
    prev_osc = osc_en;
  end

  function automatic int est_edges(int per);
    if (per == 0) return 0;
    return (W * 4) / per;
  endfunction

  function automatic bit model_low(bit prev, bit det, int edges);
    if (!det) return 1'b0;
    if (prev) return (edges < HIGK);
    return (edges < LOWK);
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic to_phase(int ph);
    @(negedge clk_ref);
    while ((cyc % W) != ph) @(negedge clk_ref);
  endtask

  // Let one mixed window pass, then one clean window, and sample mid-window.
  task automatic settle();
    to_phase(MID);
    to_phase(MID);
  endtask

  task automatic write_ctl(logic [1:0] d);
    @(negedge clk_ref);
    ctl_we = 1'b1;
    ctl_wdata = d;
    @(negedge clk_ref);
    ctl_we = 1'b0;
  endtask

  function automatic string summary_line();
    return $sformatf("%0d/%0d checks passed", checks - fails, checks);
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%s", summary_line());
      $finish;
    end
  end

  initial begin
    bit st_low;
    repeat (4) @(negedge clk_ref);
    rst = 1'b0;
    @(negedge clk_ref);
    check("R7", low_rate, 1'b0, "low_rate after reset");
    check("R7", osc_en, 1'b0, "osc_en after reset");

    // Slow clock with reset control values: detection on by default (R1, R7).
    settle();
    check("R1", low_rate, 1'b1, "slow 200ns");
    check("R7", osc_en, 1'b1, "default detect-enable drives osc_en");

    // Hysteresis band entered from the low side (R2).
    mon_per = 77;
    settle();
    check("R2", low_rate, 1'b1, "band holds low");
    mon_per = 60;
    settle();
    check("R2", low_rate, 1'b0, "fast clears low");
    check("R4", osc_en, 1'b0, "osc_en off when fast");
    // Band entered from the high side (R2).
    mon_per = 77;
    settle();
    check("R2", low_rate, 1'b0, "band holds normal");

    // Stopped clock (R3).
    mon_per = 0;
    settle();
    check("R3", low_rate, 1'b1, "stopped clock");
    check("R3", osc_en, 1'b1, "osc_en for stopped clock");

    // Mid-window disable: no effect until the boundary (R8), then cleared (R5).
    to_phase(300);
    write_ctl(2'b00);
    to_phase(900);
    check("R8", low_rate, 1'b1, "write mid-window not yet seen");
    to_phase(MID);
    check("R5", low_rate, 1'b0, "detect off clears status");
    check("R5", osc_en, 1'b0, "detect off clears osc_en");

    // Force-run with detection off and clock stopped (R6).
    write_ctl(2'b10);
    settle();
    check("R6", osc_en, 1'b1, "force with detect off");
    check("R5", low_rate, 1'b0, "status stays clear with detect off");

    // Force plus detect on a fast clock (R4, R6).
    mon_per = 40;
    write_ctl(2'b11);
    settle();
    check("R6", osc_en, 1'b1, "force on fast clock");
    check("R4", low_rate, 1'b0, "fast clock not low");

    // Random rates and control settings, outside the hysteresis band (R4).
    st_low = 1'b0;
    for (int i = 0; i < 14; i++) begin
      bit slow, det, frc, exp_low;
      slow = $urandom_range(0, 1);
      det  = $urandom_range(0, 1);
      frc  = $urandom_range(0, 1);
      mon_per = slow ? $urandom_range(90, 300) : $urandom_range(20, 66);
      write_ctl({frc, det});
      settle();
      exp_low = model_low(st_low, det, est_edges(mon_per));
      st_low = exp_low;
      check("R4", low_rate, exp_low, $sformatf("random low_rate per=%0d det=%0d", mon_per, det));
      check("R4", osc_en, frc | exp_low, $sformatf("random osc_en frc=%0d", frc));
    end

    checks++;
    if (midwin_bad != 0) begin
      fails++;
      $display("FAIL R8 mid-window output changes: actual %0d expected 0", midwin_bad);
    end

    done = 1;
    $display("%s", summary_line());
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule